// File: doc/BRIEF.md
# Four-beat burst address sequencer

This block produces the address of each beat in a four-beat burst for a synchronous burst memory. A load pulse captures the starting address. The two least significant bits of that address seed the beat sequence, and the upper bits are held for the whole burst. Each advance pulse then steps the sequence by one beat. The sequence wraps inside an aligned group of four words, so after the fourth step the address comes back to the starting word.

Two orderings are available. In linear order the low pair counts upward modulo four from the seed. In interleaved order the low pair is the seed XOR a two-bit beat count, which gives the ordering that cache-line fill controllers expect. Interleaved is the default: only a mode input that is driven low selects linear order.

Top module: `burst_addr_gen`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `burst_addr` is all zeros.
- R2: In the cycle after a clock edge where `load` is high, `burst_addr` equals the `start_addr` sampled at that edge. This holds even when `advance` is high at the same edge, because load takes priority.
- R3: With `order_sel` low (linear), after k advances since the last load, `burst_addr[1:0]` = (seed + k) mod 4. For seed 01 this gives 01,10,11,00.
- R4: With `order_sel` not driven low (high, or undriven, both meaning interleaved), after k advances since the last load, `burst_addr[1:0]` = seed XOR (k mod 4). For seed 01 this gives 01,00,11,10.
- R5: After four advances with no load in between, `burst_addr` returns to the loaded start address, in either order.
- R6: `burst_addr[ADDR_W-1:2]` keeps the value captured at the last load. Advances and changes on `start_addr` without a load leave it unchanged.
- R7: With `load` and `advance` both low, `burst_addr` holds its value, provided `order_sel` is steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture `start_addr` and restart the burst |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 selects linear order; any other value, including undriven, selects interleaved |
| start_addr | input | ADDR_W | Starting address of the burst |
| burst_addr | output | ADDR_W | Address of the current beat |

## Verification
On every cycle the assertions check that load wins over advance and that idle cycles hold the address. They also check that the upper bits do not move between loads, and that a linear step adds one. A small shadow count in the checker confirms the interleaved XOR pattern and the return to the start word after each group of four advances. The directed scenarios are the only place where full tables are compared: every seed in both orders, across the wrap. The scenarios also cover a reload in the middle of a burst and start-address changes that come without a load.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      seed_q;
  logic [1:0]      beat_q;
  logic            interleave;
  logic [1:0]      low_lin;
  logic [1:0]      low_ilv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      seed_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      hi_q   <= start_addr[ADDR_W-1:2];
      seed_q <= start_addr[1:0];
      beat_q <= '0;
    end else if (advance) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  // a mode pin that is not actively low (high, floating, unknown) means interleaved
  assign interleave = (order_sel !== 1'b0);
  assign low_lin    = seed_q + beat_q;
  assign low_ilv    = seed_q ^ beat_q;
  assign burst_addr = {hi_q, interleave ? low_ilv : low_lin};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              advance,
  input logic              order_sel,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] burst_addr
);
  logic [1:0] sh_seed;
  logic [1:0] sh_cnt;
  logic       sh_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_seed  <= '0;
      sh_cnt   <= '0;
      sh_valid <= 1'b0;
    end else if (load) begin
      sh_seed  <= start_addr[1:0];
      sh_cnt   <= '0;
      sh_valid <= 1'b1;
    end else if (advance) begin
      sh_cnt <= sh_cnt + 2'd1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || burst_addr == '0));

  p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> burst_addr == $past(start_addr));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && order_sel == 1'b0) |=>
      (order_sel != 1'b0 || burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1));

  p_interleave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && order_sel == 1'b1) |-> burst_addr[1:0] == (sh_seed ^ sh_cnt));

  p_wrap_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_cnt == 2'd0) |-> burst_addr[1:0] == sh_seed);

  p_upper_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> (!$stable(order_sel) || $stable(burst_addr)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int ADDR_W = 18;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load = 1'b0;
  logic              advance = 1'b0;
  logic              order_sel = 1'b1;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [ADDR_W-1:0] burst_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    n_checks++;
    if (burst_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, burst_addr, exp);
    end
  endtask

  function automatic logic [1:0] beat_low(input logic [1:0] s, input int k, input logic ilv);
    logic [1:0] kk = 2'(k);
    return ilv ? (s ^ kk) : (s + kk);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0);
  endtask

  // loads seed, then steps four times: each beat against the table, last one is the wrap
  task automatic t_sequence(input logic [1:0] s, input logic ilv, input logic [ADDR_W-3:0] hi);
    order_sel = ilv;
    load = 1'b1;
    start_addr = {hi, s};
    @(negedge clk);
    load = 1'b0;
    advance = 1'b1;
    check("R2 load", {hi, s});
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 4) check("R5 wrap", {hi, s});
      else if (ilv) check("R4 interleaved beat", {hi, beat_low(s, k, 1'b1)});
      else check("R3 linear beat", {hi, beat_low(s, k, 1'b0)});
    end
    advance = 1'b0;
  endtask

  task automatic t_load_priority();
    order_sel = 1'b0;
    load = 1'b1;
    start_addr = {16'h1234, 2'b10};
    @(negedge clk);
    load = 1'b0;
    advance = 1'b1;
    @(negedge clk);
    check("R3 mid burst", {16'h1234, 2'b11});
    load = 1'b1;
    start_addr = {16'h0abc, 2'b01};
    @(negedge clk);
    check("R2 load over advance", {16'h0abc, 2'b01});
    load = 1'b0;
    advance = 1'b0;
  endtask

  task automatic t_hold_and_upper();
    order_sel = 1'b1;
    load = 1'b1;
    start_addr = {16'hbeef, 2'b11};
    @(negedge clk);
    load = 1'b0;
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R4 one step", {16'hbeef, 2'b10});
    start_addr = {16'h5555, 2'b00};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 idle hold", {16'hbeef, 2'b10});
    end
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R6 upper held through advance", {16'hbeef, 2'b01});
  endtask

  initial begin
    t_reset();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        t_sequence(2'(s), 1'(m), 16'(16'h0100 * (s + 1) + m));
    t_load_priority();
    t_hold_and_upper();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule